// File: doc/BRIEF.md
# Seven-to-one parallel video serializer

The block takes one 28-bit pixel word per pixel-clock period (24 colour bits plus four control bits such as line sync, frame sync and data enable; their order inside the word is the integrator's choice) and spreads it over four serial data lanes. Each lane sends seven bits per pixel period. A fifth lane sends a forwarded clock pattern that is locked to the slot grid of the data lanes, so a receiver can recover the pixel framing.

All logic runs on a bit clock supplied from outside at seven times the pixel rate and phase-aligned to it. The pixel clock is sampled as a signal in that domain. A strap input picks which pixel-clock edge captures the word. An active-low power-down input disables every output and holds the internal state in reset. A monitor drives all five lanes low when the pixel clock stops, and lets the stream restart on its own when the clock comes back. The differential drivers, the PLL and spread-spectrum tracking lie outside the block. Output enable and the forced-low condition are plain logic signals.

Top module: `vser_top`

## Requirements
- R1: With `edge_sel` = 1 the word is captured on a rising edge of `pclk`. With `edge_sel` = 0 it is captured on a falling edge.
- R2: Data lane L, slot S (L = 0..3, S = 0..6) carries word bit 7*L + S, so `lane_data[0]` sends bits 0..6 and `lane_data[3]` sends bits 21..27.
- R3: Say a capture edge is first seen at bit-clock edge k. Then slot S of that word is on the lanes from edge k+2+S to edge k+3+S. Words from consecutive pixel periods follow each other with no gap.
- R4: `lane_clk` sends 1,1,0,0,0,1,1 in slots 0 to 6, in step with the slots of the data lanes.
- R5: While `pd_n` is 0, `lane_oe` is 0 and every lane output is 0.
- R6: After `pd_n` is released, all lanes stay low until the first capture edge, because the internal state was reset.
- R7: After MISS_LIMIT (16) bit-clock cycles with no capture edge, all five lanes are low, starting at bit-clock edge k+16 after the last capture at edge k.
- R8: During a pixel-clock pause shorter than the limit, the lanes keep repeating the slot sequence of the last word.
- R9: The first capture edge after a missing clock restarts normal output with that word, without a power-down cycle.
- R10: Changes of `pix_data` at the non-capture edge of `pclk` never reach the lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock, seven times the pixel rate |
| pd_n | input | 1 | Active-low power-down; also resets all state |
| edge_sel | input | 1 | Capture edge strap: 1 rising, 0 falling |
| pclk | input | 1 | Pixel clock, sampled in the bit-clock domain |
| pix_data | input | 28 | Pixel word: colour and control bits |
| lane_data | output | 4 | Serial data lanes |
| lane_clk | output | 1 | Forwarded clock pattern lane |
| lane_oe | output | 1 | Output enable for all five lanes |

## Verification
A corrupted capture register or a wrong slot index shows up within three bit-clock cycles of a capture, as a wrong bit in a known slot of a known lane. A slip in the shift phase moves the clock lane's 1100011 pattern off the slot grid within the same pixel period. A fault in the idle counter shows at a single bit-clock edge: the forced-low state arrives one cycle too early or too late around cycle k+16, or the pattern of the last word keeps repeating after the limit. A bad reset value shows as non-zero lanes in the first cycles after power-down is released.

// File: rtl/vser_pkg.sv
package vser_pkg;
  localparam int SLOTS      = 7;
  localparam int DATA_LANES = 4;
  localparam int MISS_LIMIT = 16;
  // forwarded clock slot pattern, bit index = slot number
  localparam logic [SLOTS-1:0] CLK_PAT = 7'b1100011;
endpackage

// File: rtl/vser_edge_mon.sv
module vser_edge_mon #(
  parameter int MISS_LIMIT = vser_pkg::MISS_LIMIT
) (
  input  logic bclk,
  input  logic pd_n,
  input  logic edge_sel,
  input  logic pclk,
  output logic cap_evt,
  output logic lost
);
  localparam int CW = $clog2(MISS_LIMIT + 1);

  logic          pclk_q;
  logic          armed;
  logic [CW-1:0] idle_cnt;
  logic          rise_seen;
  logic          fall_seen;

  assign rise_seen = pclk & ~pclk_q;
  assign fall_seen = ~pclk & pclk_q;
  assign cap_evt   = armed & (edge_sel ? rise_seen : fall_seen);

  always_ff @(posedge bclk or negedge pd_n) begin
    if (!pd_n) begin
      pclk_q   <= 1'b0;
      armed    <= 1'b0;
      idle_cnt <= '0;
      lost     <= 1'b1;
    end else begin
      pclk_q <= pclk;
      armed  <= 1'b1;
      if (cap_evt) begin
        idle_cnt <= '0;
        lost     <= 1'b0;
      end else if (!lost) begin
        if (idle_cnt == CW'(MISS_LIMIT - 1)) lost <= 1'b1;
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  AST_CAP_CLEARS_LOST: assert property (@(posedge bclk) disable iff (!pd_n)
    cap_evt |=> !lost) else $error("capture did not clear lost"); // R9
  AST_LOST_HOLDS: assert property (@(posedge bclk) disable iff (!pd_n)
    lost && !cap_evt |=> lost) else $error("lost dropped without capture"); // R7
  AST_IDLE_BOUND: assert property (@(posedge bclk) disable iff (!pd_n)
    idle_cnt <= CW'(MISS_LIMIT)) else $error("idle counter overran"); // R7
endmodule

// File: rtl/vser_lane.sv
module vser_lane #(
  parameter int SLOTS = vser_pkg::SLOTS
) (
  input  logic             bclk,
  input  logic             pd_n,
  input  logic             load,
  input  logic [SLOTS-1:0] din,
  output logic             bit_out
);
  logic [SLOTS-1:0] sh;

  always_ff @(posedge bclk or negedge pd_n) begin
    if (!pd_n) begin
      sh      <= '0;
      bit_out <= 1'b0;
    end else begin
      bit_out <= sh[0];
      if (load) sh <= din;
      else      sh <= {sh[0], sh[SLOTS-1:1]};   // rotate: repeats during a pause
    end
  end
endmodule

// File: rtl/vser_top.sv
module vser_top #(
  parameter int SLOTS      = vser_pkg::SLOTS,
  parameter int DATA_LANES = vser_pkg::DATA_LANES,
  parameter int MISS_LIMIT = vser_pkg::MISS_LIMIT,
  parameter logic [6:0] CLK_PAT = vser_pkg::CLK_PAT
) (
  input  logic                        bclk,
  input  logic                        pd_n,
  input  logic                        edge_sel,
  input  logic                        pclk,
  input  logic [SLOTS*DATA_LANES-1:0] pix_data,
  output logic [DATA_LANES-1:0]       lane_data,
  output logic                        lane_clk,
  output logic                        lane_oe
);
  localparam int WORD_W = SLOTS * DATA_LANES;

  function automatic logic [SLOTS-1:0] lane_slice(input logic [WORD_W-1:0] w,
                                                  input int unsigned lane);
    return w[lane*SLOTS +: SLOTS];
  endfunction

  logic              cap_evt;
  logic              lost;
  logic              load_evt;
  logic [WORD_W-1:0] cap_word;
  logic [DATA_LANES:0] lane_bits;
  logic              drive;

  vser_edge_mon #(.MISS_LIMIT(MISS_LIMIT)) u_mon (
    .bclk(bclk), .pd_n(pd_n), .edge_sel(edge_sel), .pclk(pclk),
    .cap_evt(cap_evt), .lost(lost)
  );

  // capture stage; the shift stage loads one cycle later
  always_ff @(posedge bclk or negedge pd_n) begin
    if (!pd_n) begin
      cap_word <= '0;
      load_evt <= 1'b0;
    end else begin
      load_evt <= cap_evt;
      if (cap_evt) cap_word <= pix_data;
    end
  end

  for (genvar g = 0; g <= DATA_LANES; g++) begin : g_lane
    logic [SLOTS-1:0] din;
    if (g < DATA_LANES) begin : g_data
      assign din = lane_slice(cap_word, g);
    end else begin : g_clk
      assign din = CLK_PAT[SLOTS-1:0];
    end
    vser_lane #(.SLOTS(SLOTS)) u_lane (
      .bclk(bclk), .pd_n(pd_n), .load(load_evt), .din(din),
      .bit_out(lane_bits[g])
    );
  end

  assign drive     = pd_n & ~lost;
  assign lane_oe   = pd_n;
  assign lane_data = drive ? lane_bits[DATA_LANES-1:0] : '0;
  assign lane_clk  = drive & lane_bits[DATA_LANES];

  AST_LOAD_AFTER_CAP: assert property (@(posedge bclk) disable iff (!pd_n)
    cap_evt |=> load_evt) else $error("shift load missing"); // R3
  AST_CLK_SLOT0: assert property (@(posedge bclk) disable iff (!pd_n)
    load_evt |=> ##1 (lane_clk == CLK_PAT[0])) else $error("clock lane slot 0"); // R4
  AST_LOST_LOW: assert property (@(posedge bclk) disable iff (!pd_n)
    lost |-> (lane_data == '0 && !lane_clk)) else $error("lanes active while lost"); // R7
endmodule

// File: tb/tb_vser_top.sv
module tb_vser_top;
  logic        bclk = 1'b0;
  logic        pd_n = 1'b0;
  logic        edge_sel = 1'b0;
  logic        pclk = 1'b1;
  logic [27:0] pix_data = '0;
  logic [3:0]  lane_data;
  logic        lane_clk;
  logic        lane_oe;

  int n_cmp = 0;
  int n_bad = 0;
  logic [27:0] prev_w;
  bit          prev_ok = 0;
  localparam logic [6:0] PAT_SLOTS = {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  always #2 bclk = ~bclk;   // 250 MHz

  vser_top dut (
    .bclk(bclk), .pd_n(pd_n), .edge_sel(edge_sel), .pclk(pclk),
    .pix_data(pix_data), .lane_data(lane_data), .lane_clk(lane_clk),
    .lane_oe(lane_oe)
  );

  function automatic logic [4:0] expect_slot(input logic [27:0] w, input int s);
    logic [27:0] t;
    t = w >> s;
    return {PAT_SLOTS[6-s], t[21], t[14], t[7], t[0]};
  endfunction

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one pixel period: seven bit-clock cycles, decoy data at the other edge
  task automatic pixel(input logic [27:0] w);
    for (int i = 0; i < 7; i++) begin
      @(negedge bclk);
      if (i < 3 && prev_ok)
        chk("R2/R3/R4 prev word", {lane_oe, lane_clk, lane_data},
            {1'b1, expect_slot(prev_w, i + 4)});
      if (i >= 3)
        chk("R1/R2/R3/R4 word", {lane_oe, lane_clk, lane_data},
            {1'b1, expect_slot(w, i - 3)});
      if (i == 0) begin
        pix_data = w;
        pclk = edge_sel;
      end
      if (i == 4) begin
        pix_data = ~w;     // R10 decoy on the non-capture edge
        pclk = ~edge_sel;
      end
    end
    prev_w = w;
    prev_ok = 1;
  endtask

  // stop pclk after the last pixel; check repeat, then forced low
  task automatic gap_test;
    for (int m = 7; m < 26; m++) begin
      @(negedge bclk);
      if (m <= 16)
        chk("R8 pause repeat", {lane_oe, lane_clk, lane_data},
            {1'b1, expect_slot(prev_w, (m - 3) % 7)});
      else
        chk("R7 lost forces low", {lane_oe, lane_clk, lane_data}, 6'b100000);
    end
    prev_ok = 0;
  endtask

  task automatic powerdown_test(input logic new_sel);
    @(negedge bclk);
    pd_n = 1'b0;
    @(negedge bclk);
    chk("R5 power-down", {lane_oe, lane_clk, lane_data}, 6'b000000);
    edge_sel = new_sel;
    pclk = ~new_sel;
    repeat (2) @(negedge bclk);
    chk("R5 power-down hold", {lane_oe, lane_clk, lane_data}, 6'b000000);
    pd_n = 1'b1;
    prev_ok = 0;
    for (int j = 0; j < 4; j++) begin
      @(negedge bclk);
      chk("R6 low after release", {lane_oe, lane_clk, lane_data}, 6'b100000);
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge bclk);
    chk("R5 reset state", {lane_oe, lane_clk, lane_data}, 6'b000000);
    powerdown_test(1'b0);                 // falling-edge capture (R1)
    pixel(28'h0000001);
    pixel(28'hFFFFFFF);
    pixel(28'h5A5A5A5);
    pixel(28'h8000000);
    pixel(28'h123ABCD);
    gap_test();
    pixel(28'h0F0F0F0);                   // R9 resume without power-down
    pixel(28'hA5C3E17);
    pixel(28'h0000080);
    gap_test();
    powerdown_test(1'b1);                 // rising-edge capture (R1)
    pixel(28'hFEDCBA9);
    pixel(28'h0000000);
    pixel(28'h7FFFFFF);
    pixel(28'h1248124);
    gap_test();
    pixel(28'h3C3C3C3);                   // R9
    pixel(28'hC0FFEE1);
    powerdown_test(1'b0);                 // mid-stream power-down, R6
    pixel(28'h6B6B6B6);
    pixel(28'h0000400);
    gap_test();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule